// File: doc/BRIEF.md
# NAND Block Lock Status Query

This block asks a NAND flash device whether one erase block is write-protected. After a start strobe it drives the lock-status query onto an 8-bit NAND bus. The query is the opcode 7Ah, followed by the block's row address in three address cycles. It then waits a programmable turnaround time, pulls the read strobe low and takes one status byte from the device.

The low three bits of that byte are decoded into three registered flags: the block is locked, the block is locked tight, and the device as a whole is locked tight. Any code outside the four defined ones sets an invalid-status flag instead. The flags and a valid indication stay steady until the next query is accepted.

The invert-area bit of the row address is always forced low inside the block. Bus timing is counted in clock cycles, with one cycle per strobe phase, so the controller can be tuned to the device's timing at any clock rate.

Top module: `nand_lock_query`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`=0, `status_vld`=0, all four flags are 0, `nand_cle`=`nand_ale`=0, `nand_we_n`=`nand_re_n`=1 and `nand_dq_oe`=0.
- R2: A rising clock edge that samples `start`=1 while idle is query cycle 0. In cycles 0 and 1, `nand_cle`=1, `nand_dq_oe`=1 and `nand_dq_o`=8'h7A. `nand_we_n` is low in cycle 0 only. `nand_cle` and `nand_ale` are never high together.
- R3: In cycles 2 to 7, `nand_ale`=1 and `nand_dq_oe`=1. Address byte i (i=0,1,2) is `blk_addr[8i+7:8i]`, least significant byte first, and is driven in cycles 2+2i and 3+2i. `nand_we_n` is low in the first of each pair. Bit 0 of `blk_addr` (the invert-area bit) is always driven as 0.
- R4: For the default turnaround of 6 cycles, cycles 8 to 13 have no strobe active and the bus undriven. `nand_re_n` is then low in cycles 14 to 16, and `nand_dq_oe` is 0 whenever `nand_re_n` is low.
- R5: `nand_dq_i` is sampled at the edge that ends cycle 16. `busy` is 1 in cycles 0 to 16. `status_vld` and the flags take their new values in cycle 17, when `busy` is 0.
- R6: The decode uses `nand_dq_i[2:0]`. 3'b001 gives locked=1, tight=1, dev_tight=1. 3'b010 gives locked=1 only. 3'b101 gives dev_tight=1 only. 3'b110 gives all flags 0. `bad_status` is 0 for all four codes, and bits 7 to 3 have no effect.
- R7: The codes 3'b000, 3'b011, 3'b100 and 3'b111 give `bad_status`=1 with locked, tight and dev_tight all 0.
- R8: `status_vld` and the flags hold their values until a start is accepted. In that query's cycle 0 they all read 0.
- R9: `start` during a query is ignored, so the query keeps its timing and `busy` lasts exactly 17 cycles. A change of `blk_addr` after cycle 0 does not alter the address bytes driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a query; accepted when idle |
| blk_addr | input | 24 | Row address of the block to query |
| busy | output | 1 | Query in progress |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus data driven to the device |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data from the device |
| status_vld | output | 1 | Decoded flags are valid |
| blk_locked | output | 1 | Block is write-protected |
| blk_tight | output | 1 | Block is locked tight |
| dev_tight | output | 1 | Device is locked tight |
| bad_status | output | 1 | Status code was not one of the four defined |

## Verification
Every bus pin has a fixed cycle after start acceptance: the command in cycles 0–1, the address bytes in cycles 2–7, the read strobe in cycles 14–16 and the decoded result in cycle 17. The reference model counts the cycles since the accepted start and derives every expected pin value from that count alone. It updates on the rising edge, exactly where the design's registers change, and the comparison runs on the falling edge, half a period later, so every pin is compared in every cycle of the query. A separate count of busy cycles confirms that a start pulse during a query leaves the 17-cycle length unchanged.

// File: rtl/nlq_pkg.sv
// Shared types and the status decode function for the lock status query.
// Assumes the status code occupies the three low bits of the returned byte.
package nlq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_GAP,
        ST_READ
    } nlq_state_t;

    typedef struct packed {
        logic locked;
        logic tight;
        logic dev_tight;
        logic bad;
    } lock_flags_t;

    // Map the three-bit lock code to flags; undefined codes give bad only.
    function automatic lock_flags_t decode_lock(input logic [2:0] code);
        lock_flags_t f;
        f = '0;
        case (code)
            3'b001:  begin f.locked = 1'b1; f.tight = 1'b1; f.dev_tight = 1'b1; end
            3'b010:  f.locked = 1'b1;
            3'b101:  f.dev_tight = 1'b1;
            3'b110:  f = '0;
            default: f.bad = 1'b1;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/nlq_seq.sv
// Query sequencer: steps through the command slot, the address slots, the
// turnaround gap and the read strobe, and produces the bus control pins.
// Assumes each write slot is two clocks (strobe low, then high) and that
// TWHR_CYC and RE_CYC are at least 1.
module nlq_seq
    import nlq_pkg::*;
#(
    parameter int ADDR_CYC = 3,
    parameter int TWHR_CYC = 6,
    parameter int RE_CYC   = 3,
    localparam int IDX_W   = (ADDR_CYC > 1) ? $clog2(ADDR_CYC) : 1,
    localparam int CNT_MAX = (TWHR_CYC > RE_CYC) ? TWHR_CYC : RE_CYC,
    localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             start_acc,
    output logic             capture,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic             dq_oe,
    output logic             is_cmd,
    output logic [IDX_W-1:0] addr_idx
);

    nlq_state_t       state_q;
    logic             phase_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;

    assign start_acc = (state_q == ST_IDLE) && start;
    assign capture   = (state_q == ST_READ) && (cnt_q == CNT_W'(RE_CYC - 1));

    // State, strobe phase, address index and wait counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= 1'b0;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_CMD;
                        phase_q <= 1'b0;
                    end
                end
                ST_CMD: begin
                    phase_q <= ~phase_q;
                    if (phase_q) begin
                        state_q <= ST_ADDR;
                        idx_q   <= '0;
                    end
                end
                ST_ADDR: begin
                    phase_q <= ~phase_q;
                    if (phase_q) begin
                        if (idx_q == IDX_W'(ADDR_CYC - 1)) begin
                            state_q <= ST_GAP;
                            cnt_q   <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (cnt_q == CNT_W'(TWHR_CYC - 1)) begin
                        state_q <= ST_READ;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_READ: begin
                    if (capture) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Bus control pins decoded from the registered state.
    always_comb begin
        busy     = (state_q != ST_IDLE);
        cle      = (state_q == ST_CMD);
        ale      = (state_q == ST_ADDR);
        dq_oe    = cle || ale;
        we_n     = !(dq_oe && !phase_q);
        re_n     = (state_q != ST_READ);
        is_cmd   = cle;
        addr_idx = idx_q;
    end

    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale)); // R2
    AST_READ_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe); // R4
    AST_BUSY_UNTIL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !capture) |=> busy); // R9

endmodule

// File: rtl/nlq_addr_fmt.sv
// Address formatter: holds the row address taken at start with the
// invert-area bit cleared, and picks the byte for the current bus slot.
// Assumes slots send the least significant address byte first.
module nlq_addr_fmt #(
    parameter int         ADDR_CYC = 3,
    parameter int         INV_BIT  = 0,
    parameter logic [7:0] CMD_OP   = 8'h7A,
    localparam int        ROW_W    = 8 * ADDR_CYC,
    localparam int        IDX_W    = (ADDR_CYC > 1) ? $clog2(ADDR_CYC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] row_in,
    input  logic             is_cmd,
    input  logic             ale,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_o
);

    logic [ROW_W-1:0] row_masked;
    logic [ROW_W-1:0] row_q;
    logic [7:0]       row_bytes [ADDR_CYC];
    logic [7:0]       addr_byte;

    // Clear the invert-area bit before storing the address.
    always_comb begin
        row_masked          = row_in;
        row_masked[INV_BIT] = 1'b0;
    end

    // Capture the address only when a query is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (load) begin
            row_q <= row_masked;
        end
    end

    for (genvar g = 0; g < ADDR_CYC; g++) begin : g_bytes
        assign row_bytes[g] = row_q[g*8 +: 8];
    end

    // Select the address byte for the current slot index.
    always_comb begin
        addr_byte = '0;
        for (int k = 0; k < ADDR_CYC; k++) begin
            if (idx == IDX_W'(k)) addr_byte = row_bytes[k];
        end
        byte_o = is_cmd ? CMD_OP : addr_byte;
    end

    AST_INV_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && idx == IDX_W'(INV_BIT / 8)) |-> !byte_o[INV_BIT % 8]); // R3

endmodule

// File: rtl/nlq_decode.sv
// Status decoder: registers the decoded lock flags at the capture edge and
// holds them, with a valid level, until the next query is accepted.
// Assumes clear and capture never occur in the same cycle.
module nlq_decode
    import nlq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        capture,
    input  logic [7:0]  dq_i,
    output logic        status_vld,
    output lock_flags_t flags
);

    // Load flags on capture, drop them when a new query starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_vld <= 1'b0;
            flags      <= '0;
        end else if (clear) begin
            status_vld <= 1'b0;
            flags      <= '0;
        end else if (capture) begin
            status_vld <= 1'b1;
            flags      <= decode_lock(dq_i[2:0]);
        end
    end

    AST_BAD_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        flags.bad |-> !(flags.locked || flags.tight || flags.dev_tight)); // R7
    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!status_vld && flags == '0)); // R8
    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_vld && !clear) |=> (status_vld && $stable(flags))); // R8

endmodule

// File: rtl/nand_lock_query.sv
// Top of the block lock status query: connects the sequencer, the address
// formatter and the status decoder to the NAND bus pins.
// Assumes the device returns the status byte while the read strobe is low.
module nand_lock_query
    import nlq_pkg::*;
#(
    parameter int         ADDR_CYC = 3,
    parameter int         TWHR_CYC = 6,
    parameter int         RE_CYC   = 3,
    parameter int         INV_BIT  = 0,
    parameter logic [7:0] CMD_OP   = 8'h7A,
    localparam int        ROW_W    = 8 * ADDR_CYC,
    localparam int        IDX_W    = (ADDR_CYC > 1) ? $clog2(ADDR_CYC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] blk_addr,
    output logic             busy,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_o,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_i,
    output logic             status_vld,
    output logic             blk_locked,
    output logic             blk_tight,
    output logic             dev_tight,
    output logic             bad_status
);

    logic             start_acc;
    logic             capture;
    logic             is_cmd;
    logic [IDX_W-1:0] addr_idx;
    lock_flags_t      flags;

    nlq_seq #(
        .ADDR_CYC (ADDR_CYC),
        .TWHR_CYC (TWHR_CYC),
        .RE_CYC   (RE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy      (busy),
        .start_acc (start_acc),
        .capture   (capture),
        .cle       (nand_cle),
        .ale       (nand_ale),
        .we_n      (nand_we_n),
        .re_n      (nand_re_n),
        .dq_oe     (nand_dq_oe),
        .is_cmd    (is_cmd),
        .addr_idx  (addr_idx)
    );

    nlq_addr_fmt #(
        .ADDR_CYC (ADDR_CYC),
        .INV_BIT  (INV_BIT),
        .CMD_OP   (CMD_OP)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start_acc),
        .row_in (blk_addr),
        .is_cmd (is_cmd),
        .ale    (nand_ale),
        .idx    (addr_idx),
        .byte_o (nand_dq_o)
    );

    nlq_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start_acc),
        .capture    (capture),
        .dq_i       (nand_dq_i),
        .status_vld (status_vld),
        .flags      (flags)
    );

    assign blk_locked = flags.locked;
    assign blk_tight  = flags.tight;
    assign dev_tight  = flags.dev_tight;
    assign bad_status = flags.bad;

    AST_RESULT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        status_vld |-> !busy); // R5

endmodule

// File: tb/nand_lock_query_test.sv
// Cycle-by-cycle reference model of the lock status query, compared with
// the design on every falling clock edge.
module nand_lock_query_test;

    localparam int TW   = 6;
    localparam int TR   = 3;
    localparam int LAST = 8 + TW + TR - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] blk_addr = '0;
    logic [7:0]  nand_dq_i = '0;
    logic        busy, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_o;
    logic        status_vld, blk_locked, blk_tight, dev_tight, bad_status;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // model state
    int          m_n = -1;
    logic [23:0] m_row = '0;
    logic        m_vld = 0, m_lk = 0, m_lt = 0, m_dt = 0, m_bad = 0;
    string       m_ftag = "R1";

    always #2.5 clk = ~clk;

    nand_lock_query uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .blk_addr   (blk_addr),
        .busy       (busy),
        .nand_cle   (nand_cle),
        .nand_ale   (nand_ale),
        .nand_we_n  (nand_we_n),
        .nand_re_n  (nand_re_n),
        .nand_dq_o  (nand_dq_o),
        .nand_dq_oe (nand_dq_oe),
        .nand_dq_i  (nand_dq_i),
        .status_vld (status_vld),
        .blk_locked (blk_locked),
        .blk_tight  (blk_tight),
        .dev_tight  (dev_tight),
        .bad_status (bad_status)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
                     tag, what, act, exp, cycles);
        end
    endtask

    // reference model: advances on the same edge as the design
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_n = -1; m_vld = 0; m_lk = 0; m_lt = 0; m_dt = 0; m_bad = 0;
            m_ftag = "R1";
        end else if (m_n >= 0) begin
            if (m_n == LAST) begin
                m_vld = 1; m_lk = 0; m_lt = 0; m_dt = 0; m_bad = 0;
                case (nand_dq_i[2:0])
                    3'b001: begin m_lk = 1; m_lt = 1; m_dt = 1; end
                    3'b010: m_lk = 1;
                    3'b101: m_dt = 1;
                    3'b110: ;
                    default: m_bad = 1;
                endcase
                m_ftag = m_bad ? "R7" : "R6";
                m_n = -1;
            end else begin
                m_n++;
            end
        end else if (start) begin
            m_n = 0;
            m_row = blk_addr;
            m_row[0] = 1'b0;
            m_vld = 0; m_lk = 0; m_lt = 0; m_dt = 0; m_bad = 0;
            m_ftag = "R8";
        end
    end

    // compare every output half a cycle after the model update
    always @(negedge clk) begin
        if (rst_n) begin
            string btag;
            logic  e_oe;
            btag = (m_n < 0) ? "R8" : (m_n < 2) ? "R2" : (m_n < 8) ? "R3" : "R4";
            e_oe = (m_n >= 0 && m_n < 8);
            check(btag, "cle", nand_cle, (m_n == 0 || m_n == 1));
            check(btag, "ale", nand_ale, (m_n >= 2 && m_n < 8));
            check(btag, "we_n", nand_we_n, !(e_oe && (m_n % 2 == 0)));
            check(btag, "re_n", nand_re_n, !(m_n >= 8 + TW && m_n <= LAST));
            check(btag, "dq_oe", nand_dq_oe, e_oe);
            if (e_oe) begin
                check(btag, "dq_o", nand_dq_o,
                      (m_n < 2) ? 8'h7A : m_row[((m_n - 2) / 2) * 8 +: 8]);
            end
            check("R5", "busy", busy, (m_n >= 0));
            check(m_ftag, "status_vld", status_vld, m_vld);
            check(m_ftag, "flags", {blk_locked, blk_tight, dev_tight, bad_status},
                  {m_lk, m_lt, m_dt, m_bad});
        end
    end

    task automatic query(input logic [23:0] addr, input logic [7:0] st);
        @(negedge clk);
        blk_addr  = addr;
        nand_dq_i = st;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (LAST + 3) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int busy_cnt;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset outputs",
              {busy, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe,
               status_vld, blk_locked, blk_tight, dev_tight, bad_status},
              11'b00011000000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after reset",
              {busy, nand_we_n, nand_re_n, status_vld}, 4'b0110);

        // R6: defined codes with noisy upper bits; R3 address patterns
        query(24'hFFFFFF, 8'hF9);   // 001, bit 0 forced low
        query(24'h123457, 8'h02);   // 010
        query(24'hA5C3E1, 8'hAD);   // 101
        query(24'h000000, 8'h36);   // 110
        // R7: undefined codes
        query(24'h800001, 8'h00);
        query(24'h7F7F7F, 8'hFB);
        query(24'h010203, 8'h04);
        query(24'hFEDCBA, 8'h57);

        // R9: start pulse and address change during a query
        @(negedge clk);
        blk_addr = 24'h333333; nand_dq_i = 8'h01; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_cnt = 1;
        for (int i = 0; i < 30; i++) begin
            if (i == 4) begin start = 1'b1; blk_addr = 24'hCCCCCC; end
            if (i == 5) start = 1'b0;
            @(negedge clk);
            if (busy) busy_cnt++;
        end
        check("R9", "busy length with mid-query start", busy_cnt, LAST + 1);

        // R8: start held high, next query accepted right after the result
        @(negedge clk);
        blk_addr = 24'h5A5A5A; nand_dq_i = 8'h0A; start = 1'b1;
        repeat (2 * (LAST + 2) + 1) @(negedge clk);
        start = 1'b0;
        repeat (LAST + 3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule